// File: doc/BRIEF.md
# Segmented Paging Address Translator

This block turns a 24-bit logical address into a physical address in two steps. First, the top bits of the address pick one entry from a small table of segment registers. Each entry holds the physical base of that segment's own page table, the highest page number the segment may use, and separate read and write permission bits. The page number is tested against that limit, and the access type is tested against the permissions. An access that fails either test is answered at once with a fault code and never reaches memory.

An access that passes both tests fetches one page table entry from memory through a read port that allows one request in flight. The entry sits at the segment's table base plus the page number times the entry size. The frame number it returns is joined with the untouched page offset to form the physical address. A segment that is never used needs no table in memory.

Segment entries are loaded through a write-only configuration port. Requests use a valid/busy handshake, and every accepted request produces exactly one single-cycle response.

Top module: `segpage_xlate`

## Requirements
- R1: After reset, busy, rsp_valid and mem_req_valid are low, and every segment entry is cleared to base 0, limit 0 and no permissions, so a read of page 0 in any segment gets fault code 2.
- R2: The logical address splits into segment = req_addr[23:20], page = req_addr[19:12] and offset = req_addr[11:0].
- R3: A page number strictly greater than the segment's limit gets fault code 1 (bounds). A page number equal to the limit is legal.
- R4: A read to a segment whose read bit is clear, or a write to a segment whose write bit is clear, gets fault code 2 (permission). When both the bounds test and the permission test fail, code 1 is reported.
- R5: A faulting request gets rsp_valid on the cycle after it is accepted, with rsp_paddr equal to 0. It issues no memory request, and busy stays low.
- R6: A legal request raises mem_req_valid on the cycle after it is accepted, with mem_req_addr = base + page*4. Both signals hold until mem_req_ready is seen.
- R7: After the entry is returned with mem_rsp_valid, rsp_valid pulses for one cycle on the next cycle. rsp_paddr = {mem_rsp_data, offset} and rsp_fault = 0.
- R8: busy is high from the acceptance of a legal request until its response. While busy is high, req_valid is ignored.
- R9: A configuration write replaces all four fields of the addressed segment entry. The new contents apply to every request accepted after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Segment entry write strobe |
| cfg_idx | input | 4 | Segment entry to write |
| cfg_base | input | 24 | Physical base of the segment's page table |
| cfg_limit | input | 8 | Highest legal page number |
| cfg_rd_ok | input | 1 | Read permission |
| cfg_wr_ok | input | 1 | Write permission |
| req_valid | input | 1 | Translation request, taken when busy is low |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_addr | input | 24 | Logical address |
| busy | output | 1 | Translation in progress |
| rsp_valid | output | 1 | Single-cycle response strobe |
| rsp_paddr | output | 24 | Physical address (0 on a fault) |
| rsp_fault | output | 2 | 0 none, 1 bounds, 2 permission |
| mem_req_valid | output | 1 | Page table entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 24 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Entry data valid |
| mem_rsp_data | input | 12 | Frame number from the entry |

## Verification
The hardest case to reach from the ports is a new request that arrives while an earlier fetch is still waiting on memory. It has to be ignored without disturbing the address already on offer. To reach this case, the stimulus stalls mem_req_ready for several cycles and holds req_valid high during the stall with an address that would fault if it were taken. It then checks that the held memory address is unchanged and that only one response appears. The sweep covers every segment, using limits that include 0-adjacent values and 255, every combination of the two permission bits, and pages at zero, at the limit, one past the limit and at the top. Ready delays and memory latencies vary from request to request.

// File: rtl/segx_pkg.sv
package segx_pkg;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_BOUNDS = 2'd1,
    FLT_PERM   = 2'd2
  } fault_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } walk_state_e;

endpackage

// File: rtl/segx_table.sv
module segx_table #(
  parameter int SEG_W  = 4,
  parameter int PAGE_W = 8,
  parameter int MEM_AW = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [SEG_W-1:0]  wr_idx,
  input  logic [MEM_AW-1:0] wr_base,
  input  logic [PAGE_W-1:0] wr_limit,
  input  logic              wr_rd_ok,
  input  logic              wr_wr_ok,
  input  logic [SEG_W-1:0]  rd_idx,
  output logic [MEM_AW-1:0] rd_base,
  output logic [PAGE_W-1:0] rd_limit,
  output logic              rd_rd_ok,
  output logic              rd_wr_ok
);

  localparam int NUM_SEG = 1 << SEG_W;

  logic [MEM_AW-1:0] base_q  [NUM_SEG];
  logic [PAGE_W-1:0] limit_q [NUM_SEG];
  logic [NUM_SEG-1:0] rdok_q;
  logic [NUM_SEG-1:0] wrok_q;

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst) begin
        base_q[g]  <= '0;
        limit_q[g] <= '0;
        rdok_q[g]  <= 1'b0;
        wrok_q[g]  <= 1'b0;
      end else if (wr_en && (wr_idx == SEG_W'(g))) begin
        base_q[g]  <= wr_base;
        limit_q[g] <= wr_limit;
        rdok_q[g]  <= wr_rd_ok;
        wrok_q[g]  <= wr_wr_ok;
      end
    end
  end

  assign rd_base  = base_q[rd_idx];
  assign rd_limit = limit_q[rd_idx];
  assign rd_rd_ok = rdok_q[rd_idx];
  assign rd_wr_ok = wrok_q[rd_idx];

endmodule

// File: rtl/segx_check.sv
module segx_check
  import segx_pkg::*;
#(
  parameter int PAGE_W    = 8,
  parameter int MEM_AW    = 24,
  parameter int PTE_SHIFT = 2
) (
  input  logic [MEM_AW-1:0] seg_base,
  input  logic [PAGE_W-1:0] seg_limit,
  input  logic              seg_rd_ok,
  input  logic              seg_wr_ok,
  input  logic [PAGE_W-1:0] page,
  input  logic              is_write,
  output fault_e            fault,
  output logic [MEM_AW-1:0] pte_addr
);

  logic over_limit;
  logic denied;

  assign over_limit = page > seg_limit;
  assign denied     = is_write ? !seg_wr_ok : !seg_rd_ok;

  always_comb begin
    if (over_limit)  fault = FLT_BOUNDS;
    else if (denied) fault = FLT_PERM;
    else             fault = FLT_NONE;
  end

  assign pte_addr = seg_base + (MEM_AW'(page) << PTE_SHIFT);

endmodule

// File: rtl/segx_walker.sv
module segx_walker
  import segx_pkg::*;
#(
  parameter int OFF_W   = 12,
  parameter int FRAME_W = 12,
  parameter int MEM_AW  = 24,
  localparam int PA_W   = FRAME_W + OFF_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [OFF_W-1:0]   req_offset,
  input  fault_e             chk_fault,
  input  logic [MEM_AW-1:0]  chk_pte_addr,
  output logic               busy,
  output logic               rsp_valid,
  output logic [PA_W-1:0]    rsp_paddr,
  output logic [1:0]         rsp_fault,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [MEM_AW-1:0]  mem_req_addr,
  input  logic               mem_rsp_valid,
  input  logic [FRAME_W-1:0] mem_rsp_data
);

  walk_state_e       state_q;
  logic [OFF_W-1:0]  off_q;
  logic              mreq_q;
  logic [MEM_AW-1:0] maddr_q;
  logic              rsp_q;
  logic [PA_W-1:0]   paddr_q;
  fault_e            fault_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      off_q   <= '0;
      mreq_q  <= 1'b0;
      maddr_q <= '0;
      rsp_q   <= 1'b0;
      paddr_q <= '0;
      fault_q <= FLT_NONE;
    end else begin
      rsp_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            if (chk_fault != FLT_NONE) begin
              rsp_q   <= 1'b1;
              fault_q <= chk_fault;
              paddr_q <= '0;
            end else begin
              state_q <= ST_ISSUE;
              mreq_q  <= 1'b1;
              maddr_q <= chk_pte_addr;
              off_q   <= req_offset;
            end
          end
        end
        ST_ISSUE: begin
          if (mem_req_ready) begin
            mreq_q  <= 1'b0;
            state_q <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (mem_rsp_valid) begin
            rsp_q   <= 1'b1;
            fault_q <= FLT_NONE;
            paddr_q <= {mem_rsp_data, off_q};
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy          = state_q != ST_IDLE;
  assign rsp_valid     = rsp_q;
  assign rsp_paddr     = paddr_q;
  assign rsp_fault     = fault_q;
  assign mem_req_valid = mreq_q;
  assign mem_req_addr  = maddr_q;

endmodule

// File: rtl/segpage_xlate.sv
module segpage_xlate
  import segx_pkg::*;
#(
  parameter int SEG_W     = 4,
  parameter int PAGE_W    = 8,
  parameter int OFF_W     = 12,
  parameter int FRAME_W   = 12,
  parameter int MEM_AW    = 24,
  parameter int PTE_BYTES = 4,
  localparam int LA_W      = SEG_W + PAGE_W + OFF_W,
  localparam int PA_W      = FRAME_W + OFF_W,
  localparam int PTE_SHIFT = $clog2(PTE_BYTES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [SEG_W-1:0]   cfg_idx,
  input  logic [MEM_AW-1:0]  cfg_base,
  input  logic [PAGE_W-1:0]  cfg_limit,
  input  logic               cfg_rd_ok,
  input  logic               cfg_wr_ok,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [LA_W-1:0]    req_addr,
  output logic               busy,
  output logic               rsp_valid,
  output logic [PA_W-1:0]    rsp_paddr,
  output logic [1:0]         rsp_fault,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [MEM_AW-1:0]  mem_req_addr,
  input  logic               mem_rsp_valid,
  input  logic [FRAME_W-1:0] mem_rsp_data
);

  logic [SEG_W-1:0]  la_seg;
  logic [PAGE_W-1:0] la_page;
  logic [OFF_W-1:0]  la_off;
  logic [MEM_AW-1:0] ent_base;
  logic [PAGE_W-1:0] ent_limit;
  logic              ent_rd_ok;
  logic              ent_wr_ok;
  fault_e            chk_fault;
  logic [MEM_AW-1:0] chk_pte_addr;

  assign la_seg  = req_addr[LA_W-1 -: SEG_W];
  assign la_page = req_addr[OFF_W +: PAGE_W];
  assign la_off  = req_addr[OFF_W-1:0];

  segx_table #(
    .SEG_W(SEG_W), .PAGE_W(PAGE_W), .MEM_AW(MEM_AW)
  ) u_table (
    .clk(clk), .rst(rst),
    .wr_en(cfg_we), .wr_idx(cfg_idx), .wr_base(cfg_base),
    .wr_limit(cfg_limit), .wr_rd_ok(cfg_rd_ok), .wr_wr_ok(cfg_wr_ok),
    .rd_idx(la_seg), .rd_base(ent_base), .rd_limit(ent_limit),
    .rd_rd_ok(ent_rd_ok), .rd_wr_ok(ent_wr_ok)
  );

  segx_check #(
    .PAGE_W(PAGE_W), .MEM_AW(MEM_AW), .PTE_SHIFT(PTE_SHIFT)
  ) u_check (
    .seg_base(ent_base), .seg_limit(ent_limit),
    .seg_rd_ok(ent_rd_ok), .seg_wr_ok(ent_wr_ok),
    .page(la_page), .is_write(req_write),
    .fault(chk_fault), .pte_addr(chk_pte_addr)
  );

  segx_walker #(
    .OFF_W(OFF_W), .FRAME_W(FRAME_W), .MEM_AW(MEM_AW)
  ) u_walker (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_offset(la_off),
    .chk_fault(chk_fault), .chk_pte_addr(chk_pte_addr),
    .busy(busy), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
    .rsp_fault(rsp_fault),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data)
  );

endmodule

// File: rtl/segx_checker.sv
module segx_checker #(
  parameter int PA_W   = 24,
  parameter int MEM_AW = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              rsp_valid,
  input logic [PA_W-1:0]   rsp_paddr,
  input logic [1:0]        rsp_fault,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [MEM_AW-1:0] mem_req_addr,
  input logic              mem_rsp_valid
);

  a_r6_req_held: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  a_r8_idle_no_mem: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req_valid);

  a_r8_busy_holds: assert property (@(posedge clk) disable iff (rst)
    busy && !mem_rsp_valid |=> busy);

  a_r5_fault_no_walk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_fault != 2'd0 |-> !busy && !mem_req_valid && rsp_paddr == '0);

  a_r7_ok_after_mem: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_fault == 2'd0 |-> $past(mem_rsp_valid) && $past(busy) && !busy);

  a_r4_code_legal: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> rsp_fault != 2'd3);

endmodule

bind segpage_xlate segx_checker #(.PA_W(PA_W), .MEM_AW(MEM_AW)) u_segx_checker (
  .clk(clk), .rst(rst), .busy(busy), .rsp_valid(rsp_valid),
  .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid)
);

// File: tb/segpage_xlate_tb.sv
module segpage_xlate_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_idx = '0;
  logic [23:0] cfg_base = '0;
  logic [7:0]  cfg_limit = '0;
  logic        cfg_rd_ok = 1'b0;
  logic        cfg_wr_ok = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [23:0] req_addr = '0;
  logic        busy;
  logic        rsp_valid;
  logic [23:0] rsp_paddr;
  logic [1:0]  rsp_fault;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [23:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [11:0] mem_rsp_data = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int seg_base [16];
  int seg_lim  [16];
  bit seg_rd   [16];
  bit seg_wr   [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  segpage_xlate u_dut (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_base(cfg_base),
    .cfg_limit(cfg_limit), .cfg_rd_ok(cfg_rd_ok), .cfg_wr_ok(cfg_wr_ok),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .busy(busy), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
    .rsp_fault(rsp_fault),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int frame_of(input int a);
    return (a * 7 + 3) & 12'hFFF;
  endfunction

  task automatic cfg_write(input int s, input int b, input int l, input bit r, input bit w);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 4'(s); cfg_base = 24'(b);
    cfg_limit = 8'(l); cfg_rd_ok = r; cfg_wr_ok = w;
    seg_base[s] = b; seg_lim[s] = l; seg_rd[s] = r; seg_wr[s] = w;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Segment 0 is never writable-read: a read to it always faults (used for R8 noise).
  task automatic xlate(input int s, input int p, input int off, input bit wr,
                       input int rdly, input int lat);
    int exp_f;
    int exp_a;
    int fr;
    if (p > seg_lim[s]) exp_f = 1;
    else if (wr ? !seg_wr[s] : !seg_rd[s]) exp_f = 2;
    else exp_f = 0;
    exp_a = (seg_base[s] + p * 4) & 24'hFFFFFF;
    fr = frame_of(exp_a);
    @(negedge clk);
    chk("R8 idle before request", busy, 0);
    req_valid = 1'b1; req_write = wr;
    req_addr = {4'(s), 8'(p), 12'(off)};
    @(negedge clk);
    req_valid = 1'b0;
    if (exp_f != 0) begin
      chk(exp_f == 1 ? "R3 bounds fault code" : "R4 permission fault code", rsp_fault, exp_f);
      chk("R5 fault response strobe", rsp_valid, 1);
      chk("R5 fault paddr zero", rsp_paddr, 0);
      chk("R5 no memory request", mem_req_valid, 0);
      chk("R5 not busy", busy, 0);
    end else begin
      chk("R8 busy after accept", busy, 1);
      chk("R6 mem request raised", mem_req_valid, 1);
      chk("R6 R2 entry address", mem_req_addr, exp_a);
      chk("R7 no early response", rsp_valid, 0);
      for (int i = 0; i < rdly; i++) begin
        req_valid = 1'b1; req_write = 1'b0; req_addr = 24'h000000;
        @(negedge clk);
        chk("R6 request held", mem_req_valid, 1);
        chk("R8 address unchanged while busy", mem_req_addr, exp_a);
        chk("R8 busy request ignored", rsp_valid, 0);
      end
      req_valid = 1'b0;
      mem_req_ready = 1'b1;
      @(negedge clk);
      mem_req_ready = 1'b0;
      chk("R6 request dropped after ready", mem_req_valid, 0);
      chk("R8 busy while waiting", busy, 1);
      for (int i = 0; i < lat; i++) begin
        @(negedge clk);
        chk("R7 no response before data", rsp_valid, 0);
      end
      mem_rsp_valid = 1'b1; mem_rsp_data = 12'(fr);
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      chk("R7 response strobe", rsp_valid, 1);
      chk("R7 fault none", rsp_fault, 0);
      chk("R7 R2 physical address", rsp_paddr, (fr << 12) | (off & 12'hFFF));
      chk("R8 busy cleared", busy, 0);
    end
    @(negedge clk);
    chk("R7 single-cycle response", rsp_valid, 0);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < 16; s++) begin
      seg_base[s] = 0; seg_lim[s] = 0; seg_rd[s] = 0; seg_wr[s] = 0;
    end
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", busy, 0);
    chk("R1 rsp_valid in reset", rsp_valid, 0);
    chk("R1 mem_req_valid in reset", mem_req_valid, 0);
    rst = 1'b0;
    // R1: cleared entries deny reads of page 0
    xlate(5, 0, 12'h123, 1'b0, 0, 0);
    xlate(15, 0, 12'h000, 1'b1, 0, 0);

    for (int s = 0; s < 16; s++)
      cfg_write(s, s * 24'h4000 + s * 16, (s == 15) ? 255 : (s * 37 + 5) % 256,
                (s % 3) != 0, (s % 2) == 0);

    // Sweep: every segment, pages at 0, mid, limit, limit+1, 255; both access types
    for (int s = 0; s < 16; s++) begin
      for (int k = 0; k < 5; k++) begin
        int p;
        case (k)
          0: p = 0;
          1: p = seg_lim[s] / 2;
          2: p = seg_lim[s];
          3: p = (seg_lim[s] < 255) ? seg_lim[s] + 1 : 255;
          default: p = 255;
        endcase
        for (int w = 0; w < 2; w++)
          xlate(s, p, (s * 300 + k * 77 + w * 4095) & 12'hFFF, w[0], (k + w) % 4, s % 4);
      end
    end

    // R9: new base and permissions apply to later requests
    cfg_write(2, 24'hABC000, 10, 1'b1, 1'b0);
    xlate(2, 10, 12'hFFF, 1'b0, 2, 1);
    xlate(2, 10, 12'h001, 1'b1, 0, 0);
    xlate(2, 11, 12'h001, 1'b0, 0, 0);
    cfg_write(2, 24'hFFFFF0, 255, 1'b0, 1'b1);
    xlate(2, 255, 12'h5A5, 1'b1, 1, 2);
    xlate(2, 3, 12'h5A5, 1'b0, 0, 0);
    // R4: bounds reported over permission on a segment with no rights
    cfg_write(7, 24'h001000, 4, 1'b0, 1'b0);
    xlate(7, 5, 12'h010, 1'b1, 0, 0);
    xlate(7, 4, 12'h010, 1'b1, 0, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule